// File: doc/BRIEF.md
# Lookahead In-Order Tree Sorter

The block walks a binary search tree held in an internal dual-port node memory and streams the stored keys in ascending order. Each node word holds a key and two child links. A current-node register holds the node being visited. While a node is loaded, both of its children are read in the same cycle, one per memory port. The engine can therefore see whether a child is a leaf, or has only a right subtree, before it decides to descend.

Leaf children are emitted straight from the port read, with no stack push and no reload. A child with no left subtree is emitted, and the walk then descends directly into that child's right subtree. A single child-handling step serves both sides, with the side chosen by a selector register and a multiplexer. The return stack keeps only the parent address and the side to resume on. Parent contents are read again from memory on return.

Nodes are written through a simple write port before a run. A one-cycle start pulse begins the walk. The keys then appear as single-cycle valid strobes, and a one-cycle done pulse ends the run.

Top module: `tsort_top`

## Requirements
- R1: While reset is asserted and after it is released, with no start, `valid_o` and `done_o` are 0.
- R2: Node encoding: the word at an address holds a key and a left and a right link. A link value of 0 means there is no child. The root always sits at address 0, so no child is ever stored at address 0.
- R3: After a start pulse, every node reachable from the root is emitted exactly once on `key_o`, with `valid_o` high for one cycle per key. The keys come out in strictly ascending order for a tree of distinct keys.
- R4: A tree that is only a root emits that one key, followed by a done pulse.
- R5: `done_o` is a one-cycle pulse after the last key. It is never high in the same cycle as `valid_o`.
- R6: A child that is a leaf is emitted without a reload. For a root with two leaf children, the three keys appear on three consecutive cycles and `done_o` follows on the next cycle.
- R7: A start pulse while a walk is in progress is ignored: the run's output is unchanged. After done, no key is emitted until the next start.
- R8: The return stack holds `STK_DEPTH` entries. Fully degenerate trees of `2**ADDR_W` nodes (left chain or right chain) sort correctly and never push onto a full stack.
- R9: A child with no left subtree but with a right subtree is emitted first. Its right subtree is then walked, and the output stays in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Node write strobe |
| wr_addr_i | input | ADDR_W | Node address to write |
| wr_key_i | input | KEY_W | Key of the written node |
| wr_lnk_l_i | input | ADDR_W | Left child link (0 = none) |
| wr_lnk_r_i | input | ADDR_W | Right child link (0 = none) |
| start_i | input | 1 | Start pulse, taken only when idle |
| valid_o | output | 1 | Key strobe |
| key_o | output | KEY_W | Emitted key |
| done_o | output | 1 | End-of-walk pulse |

## Verification
Trees are built in the bench by ordinary insertion from key sequences that the bench computes, and the expected output is the sorted key list. The patterns are:
- The mixed ten-node tree, where one left child has only a right subtree, which separates the direct-jump path from plain recursion.
- A lone root and a root with two leaves, which pin down the leaf-emission timing.
- Fully ascending and fully descending chains, which stress the two extremes of stack depth.
- Several multiplicative permutations of a full memory, which give varied mixed shapes.

A start pulse injected mid-run checks that a running walk is not disturbed.

// File: rtl/tsort_pkg.sv
package tsort_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_NODE, ST_SIDE, ST_EMIT, ST_RET
  } st_e;

  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;
endpackage

// File: rtl/tsort_ram.sv
module tsort_ram #(
  parameter int KW = 8,
  parameter int AW = 5
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        wa_i,
  input  logic [KW+2*AW-1:0]   wd_i,
  input  logic                 re_i,
  input  logic [AW-1:0]        ra_a_i,
  input  logic [AW-1:0]        ra_b_i,
  output logic [KW+2*AW-1:0]   qa_o,
  output logic [KW+2*AW-1:0]   qb_o
);
  localparam int WW = KW + 2*AW;
  localparam int NW = 1 << AW;

  logic [WW-1:0] mem [NW];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
    // outputs hold between reads so child words stay visible
    if (re_i) begin
      qa_o <= mem[ra_a_i];
      qb_o <= mem[ra_b_i];
    end
  end
endmodule

// File: rtl/tsort_stack.sv
module tsort_stack #(
  parameter int EW    = 6,
  parameter int DEPTH = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [EW-1:0] din_i,
  output logic [EW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [IW-1:0] wr_idx, top_idx;

  assign wr_idx  = IW'(ptr);
  assign top_idx = IW'(ptr - 1'b1);
  assign top_o   = mem[top_idx];
  assign empty_o = (ptr == '0);
  assign full_o  = (ptr == PW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[wr_idx] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ptr <= '0;
    else if (push_i && !full_o)   ptr <= ptr + 1'b1;
    else if (pop_i && !empty_o)   ptr <= ptr - 1'b1;
  end
endmodule

// File: rtl/tsort_ctrl.sv
module tsort_ctrl
  import tsort_pkg::*;
#(
  parameter int KW = 8,
  parameter int AW = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [KW+2*AW-1:0] qa_i,
  input  logic [KW+2*AW-1:0] qb_i,
  output logic               re_o,
  output logic [AW-1:0]      ra_a_o,
  output logic [AW-1:0]      ra_b_o,
  input  logic [AW:0]        stk_top_i,
  input  logic               stk_empty_i,
  output logic               push_o,
  output logic               pop_o,
  output logic [AW:0]        push_d_o,
  output logic               valid_o,
  output logic [KW-1:0]      key_o,
  output logic               done_o
);
  localparam int WW = KW + 2*AW;

  st_e   st;
  side_e side, rsm_side;
  logic  rsm;
  logic [AW-1:0] cur, buf_l, buf_r;
  logic [KW-1:0] buf_k;

  logic [KW-1:0] qa_k, ch_k;
  logic [AW-1:0] qa_l, qa_r, ch_l, ch_r, ch_lnk;
  logic [WW-1:0] ch_w;

  assign qa_k = qa_i[WW-1 -: KW];
  assign qa_l = qa_i[2*AW-1 -: AW];
  assign qa_r = qa_i[AW-1:0];

  // side selector muxes the shared child handler
  assign ch_w   = (side == SIDE_L) ? qa_i : qb_i;
  assign ch_lnk = (side == SIDE_L) ? buf_l : buf_r;
  assign ch_k   = ch_w[WW-1 -: KW];
  assign ch_l   = ch_w[2*AW-1 -: AW];
  assign ch_r   = ch_w[AW-1:0];

  assign re_o   = (st == ST_RD) || (st == ST_NODE);
  assign ra_a_o = (st == ST_NODE) ? qa_l : cur;
  assign ra_b_o = (st == ST_NODE) ? qa_r : cur;

  assign push_o   = (st == ST_SIDE) && (ch_lnk != '0) && ((ch_l != '0) || (ch_r != '0));
  assign push_d_o = {cur, side};
  assign pop_o    = (st == ST_RET) && !stk_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      side     <= SIDE_L;
      rsm_side <= SIDE_L;
      rsm      <= 1'b0;
      cur      <= '0;
      buf_k    <= '0;
      buf_l    <= '0;
      buf_r    <= '0;
      valid_o  <= 1'b0;
      key_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          cur <= '0;
          rsm <= 1'b0;
          st  <= ST_RD;
        end
        ST_RD: st <= ST_NODE;
        ST_NODE: begin
          buf_k <= qa_k;
          buf_l <= qa_l;
          buf_r <= qa_r;
          if (rsm) begin
            rsm <= 1'b0;
            st  <= (rsm_side == SIDE_L) ? ST_EMIT : ST_RET;
          end else begin
            side <= SIDE_L;
            st   <= ST_SIDE;
          end
        end
        ST_SIDE: begin
          if (ch_lnk != '0 && ch_l != '0) begin
            cur <= ch_lnk;
            st  <= ST_RD;
          end else if (ch_lnk != '0 && ch_r != '0) begin
            // no left subtree: emit child, then walk its right subtree
            valid_o <= 1'b1;
            key_o   <= ch_k;
            cur     <= ch_r;
            st      <= ST_RD;
          end else begin
            if (ch_lnk != '0) begin
              valid_o <= 1'b1;
              key_o   <= ch_k;
            end
            st <= (side == SIDE_L) ? ST_EMIT : ST_RET;
          end
        end
        ST_EMIT: begin
          valid_o <= 1'b1;
          key_o   <= buf_k;
          side    <= SIDE_R;
          st      <= ST_SIDE;
        end
        ST_RET: begin
          if (stk_empty_i) begin
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            cur      <= stk_top_i[AW:1];
            rsm_side <= side_e'(stk_top_i[0]);
            rsm      <= 1'b1;
            st       <= ST_RD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsort_top.sv
module tsort_top #(
  parameter int KEY_W     = 8,
  parameter int ADDR_W    = 5,
  parameter int STK_DEPTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [KEY_W-1:0]  wr_key_i,
  input  logic [ADDR_W-1:0] wr_lnk_l_i,
  input  logic [ADDR_W-1:0] wr_lnk_r_i,
  input  logic              start_i,
  output logic              valid_o,
  output logic [KEY_W-1:0]  key_o,
  output logic              done_o
);
  localparam int WW = KEY_W + 2*ADDR_W;
  localparam int EW = ADDR_W + 1;

  logic [WW-1:0]     qa, qb;
  logic              re;
  logic [ADDR_W-1:0] ra_a, ra_b;
  logic [EW-1:0]     stk_top, push_d;
  logic              stk_empty, stk_full, push_w, pop_w;

  tsort_ram #(.KW(KEY_W), .AW(ADDR_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr_en_i),
    .wa_i   (wr_addr_i),
    .wd_i   ({wr_key_i, wr_lnk_l_i, wr_lnk_r_i}),
    .re_i   (re),
    .ra_a_i (ra_a),
    .ra_b_i (ra_b),
    .qa_o   (qa),
    .qb_o   (qb)
  );

  tsort_stack #(.EW(EW), .DEPTH(STK_DEPTH)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_w),
    .pop_i   (pop_w),
    .din_i   (push_d),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  tsort_ctrl #(.KW(KEY_W), .AW(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .qa_i        (qa),
    .qb_i        (qb),
    .re_o        (re),
    .ra_a_o      (ra_a),
    .ra_b_o      (ra_b),
    .stk_top_i   (stk_top),
    .stk_empty_i (stk_empty),
    .push_o      (push_w),
    .pop_o       (pop_w),
    .push_d_o    (push_d),
    .valid_o     (valid_o),
    .key_o       (key_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/tsort_chk.sv
module tsort_chk #(
  parameter int KW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          valid_i,
  input logic [KW-1:0] key_i,
  input logic          done_i,
  input logic          push_i,
  input logic          full_i
);
  logic          busy, seen;
  logic [KW-1:0] prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
      seen <= 1'b0;
      prev <= '0;
    end else begin
      if (!busy && start_i) begin
        busy <= 1'b1;
        seen <= 1'b0;
      end else if (done_i) begin
        busy <= 1'b0;
      end
      if (valid_i) begin
        prev <= key_i;
        seen <= 1'b1;
      end
    end
  end

  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !valid_i && !done_i);
  a_r3_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && seen |-> key_i > prev);
  a_r5_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && done_i));
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_i);
endmodule

bind tsort_top tsort_chk #(.KW(KEY_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .valid_i (valid_o),
  .key_i   (key_o),
  .done_i  (done_o),
  .push_i  (push_w),
  .full_i  (stk_full)
);

// File: tb/sim_tsort_top.sv
`timescale 1ns/1ps
module sim_tsort_top;
  localparam int KW = 8;
  localparam int AW = 5;
  localparam int NN = 1 << AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, start_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0, wr_lnk_l_i = '0, wr_lnk_r_i = '0;
  logic [KW-1:0] wr_key_i = '0;
  logic valid_o, done_o;
  logic [KW-1:0] key_o;

  int n_tests = 0, n_fail = 0;
  int kv[NN], lk[NN], rk[NN], ex[NN];
  int got[256], gcyc[256];
  int cnt, done_cyc;

  always #4 clk = ~clk;

  tsort_top #(.KEY_W(KW), .ADDR_W(AW), .STK_DEPTH(NN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_key_i(wr_key_i), .wr_lnk_l_i(wr_lnk_l_i), .wr_lnk_r_i(wr_lnk_r_i),
    .start_i(start_i), .valid_o(valid_o), .key_o(key_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // insert kv[0..n-1] in order, write nodes, compute sorted expectation
  task automatic build(input int n);
    for (int i = 0; i < n; i++) begin lk[i] = 0; rk[i] = 0; end
    for (int i = 1; i < n; i++) begin
      int p = 0;
      for (int g = 0; g < NN; g++) begin
        if (kv[i] < kv[p]) begin
          if (lk[p] == 0) begin lk[p] = i; break; end
          p = lk[p];
        end else begin
          if (rk[p] == 0) begin rk[p] = i; break; end
          p = rk[p];
        end
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = AW'(i); wr_key_i = KW'(kv[i]);
      wr_lnk_l_i = AW'(lk[i]); wr_lnk_r_i = AW'(rk[i]);
    end
    @(negedge clk); wr_en_i = 1'b0;
    for (int i = 0; i < n; i++) ex[i] = kv[i];
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n - 1 - i; j++)
        if (ex[j] > ex[j+1]) begin int t = ex[j]; ex[j] = ex[j+1]; ex[j+1] = t; end
  endtask

  task automatic run(input int n, input bit restart, input string req);
    bit seen_done = 0;
    cnt = 0; done_cyc = -1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int c = 1; c < 4000; c++) begin
      start_i = (restart && (c == 3 || c == 20)) ? 1'b1 : 1'b0;
      if (valid_o) begin
        if (cnt < 256) begin got[cnt] = int'(key_o); gcyc[cnt] = c; end
        cnt++;
      end
      if (valid_o && done_o) chk(1'b0, "R5 excl", 1, 0);
      if (done_o) begin seen_done = 1; done_cyc = c; break; end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(seen_done, {req, " R5 done seen"}, int'(seen_done), 1);
    chk(cnt == n, {req, " R3 count"}, cnt, n);
    for (int i = 0; i < n && i < cnt; i++)
      chk(got[i] == ex[i], {req, " R3 order"}, got[i], ex[i]);
    @(negedge clk);
    chk(!done_o, {req, " R5 pulse"}, int'(done_o), 0);
    for (int k = 0; k < 4; k++) begin
      chk(!valid_o, {req, " R7 quiet after done"}, int'(valid_o), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid_o && !done_o, "R1 in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!valid_o && !done_o, "R1 after reset", int'(done_o), 0);

    // R9 / R2: mixed tree, child 20 has only a right subtree
    kv[0]=19; kv[1]=17; kv[2]=22; kv[3]=11; kv[4]=20;
    kv[5]=35; kv[6]=7;  kv[7]=15; kv[8]=21; kv[9]=31;
    build(10);
    run(10, 1'b0, "R9 mixed");

    // R4: root only
    kv[0] = 42;
    build(1);
    run(1, 1'b0, "R4 root");

    // R6: root with two leaf children -> three consecutive keys, done next
    kv[0] = 50; kv[1] = 30; kv[2] = 70;
    build(3);
    run(3, 1'b0, "R6 leaves");
    chk(gcyc[1] == gcyc[0] + 1, "R6 consecutive", gcyc[1] - gcyc[0], 1);
    chk(gcyc[2] == gcyc[1] + 1, "R6 consecutive", gcyc[2] - gcyc[1], 1);
    chk(done_cyc == gcyc[2] + 1, "R6 done timing", done_cyc - gcyc[2], 1);

    // R8: right chain and left chain over the full memory
    for (int i = 0; i < NN; i++) kv[i] = i + 1;
    build(NN);
    run(NN, 1'b0, "R8 asc chain");
    for (int i = 0; i < NN; i++) kv[i] = NN - i;
    build(NN);
    run(NN, 1'b0, "R8 desc chain");

    // R3: permutation sweep
    for (int m = 3; m <= 13; m += 2) begin
      for (int i = 0; i < NN; i++) kv[i] = ((m * i + 7) % NN) + 1;
      build(NN);
      run(NN, 1'b0, "R3 sweep");
    end

    // R7: start pulses mid-walk are ignored
    for (int i = 0; i < NN; i++) kv[i] = ((5 * i + 11) % NN) + 100;
    build(NN);
    run(NN, 1'b1, "R7 restart");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule